// File: doc/BRIEF.md
# Page Translation Buffer with Permission Check

This block maps the upper bits of a virtual address (the virtual page) to a 12-bit physical page. It holds a small, fully associative set of page descriptors. Each descriptor carries a virtual-page tag, a physical page, a valid flag and separate read, write and execute rights. On a lookup, every stored tag is compared against the requested page at once. One cycle later the block reports one of three outcomes: a hit with the physical address, a miss, or a protection fault.

Descriptors come in through a load port. Each load goes into the slot named by a round-robin pointer, which then advances. A flush input invalidates every descriptor in one cycle. The page offset passes through untranslated. When several descriptors match, the lowest-numbered one is used and a multi-match flag is raised.

Top module: `page_xlate_buf`

## Requirements
- R1: After reset, `rsp_valid` is 0 and no descriptor is valid, so the first lookup of any page reports a miss.
- R2: A request presented with `req_valid`=1 at a rising edge produces a response with `rsp_valid`=1 after that same edge. When `req_valid`=0, `rsp_valid` is 0 after the edge.
- R3: On a permitted hit, `rsp_hit`=1 and `rsp_paddr` equals the stored physical page in its upper 12 bits, joined with the request's low `OFF_W` offset bits.
- R4: When no valid descriptor has a matching tag, `rsp_miss`=1 and `rsp_paddr`=0.
- R5: A descriptor loaded with `ld_valid`=0 never produces a hit; a lookup of its page reports a miss.
- R6: `req_kind` encodes 2'b00 read, 2'b01 write, 2'b10 instruction fetch and 2'b11 reserved. A matching valid descriptor whose right for the requested kind is clear raises `rsp_fault`, and the reserved kind always faults. A fault forces `rsp_paddr`=0.
- R7: Loads fill slots 0, 1, ... `ENTRIES-1` and then wrap to slot 0. After `ENTRIES`+1 loads following a flush, the first page loaded is gone and the rest still hit.
- R8: `flush_all` invalidates every descriptor in one cycle and returns the load pointer to slot 0. A load in the same cycle as a flush is dropped.
- R9: When two or more valid descriptors match, the lowest-numbered slot supplies the translation and `rsp_multi`=1. With a single match, `rsp_multi`=0.
- R10: A lookup issued in the same cycle as a load of the same page sees the contents from before the load.
- R11: When `rsp_valid`=1, exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is 1. When `rsp_valid`=0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| ld_en | input | 1 | Write a descriptor into the round-robin slot |
| ld_vpn | input | VA_W-OFF_W | Virtual page tag to store |
| ld_ppn | input | PPN_W | Physical page to store |
| ld_valid | input | 1 | Valid flag of the stored descriptor |
| ld_rd | input | 1 | Read right |
| ld_wr | input | 1 | Write right |
| ld_ex | input | 1 | Execute (fetch) right |
| flush_all | input | 1 | Invalidate all descriptors |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No valid descriptor matched |
| rsp_fault | output | 1 | Right for the access kind missing |
| rsp_multi | output | 1 | More than one valid descriptor matched |
| rsp_paddr | output | PPN_W+OFF_W | Physical address, zero unless hit |

## Verification
Two operations can land in the same clock edge. A lookup can coincide with a load of the very page it asks for, and a flush can coincide with a load. The bench drives both pairs in one cycle. For the first pair, it judges that the lookup reports a miss and that the next lookup of that page hits. For the second, it judges that the loaded page still misses afterwards, and that a later load lands in slot 0 and survives a full round of fills.

// File: rtl/page_xlate_buf.sv
module page_xlate_buf #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 24,
  parameter int OFF_W   = 10,
  parameter int PPN_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             ld_en,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PPN_W-1:0] ld_ppn,
  input  logic             ld_valid,
  input  logic             ld_rd,
  input  logic             ld_wr,
  input  logic             ld_ex,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic             rsp_multi,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   ptr_q;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] req_off = req_vaddr[OFF_W-1:0];

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == req_vpn);
  end

  logic [IDX_W-1:0] win;
  always_comb begin
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) win = IDX_W'(i);
  end

  wire any_hit  = |match;
  wire multi    = (match & (match - 1'b1)) != '0;
  wire [2:0] wp = perm_q[win];

  logic allowed;
  always_comb begin
    case (req_kind)
      2'b00:   allowed = wp[0];
      2'b01:   allowed = wp[1];
      2'b10:   allowed = wp[2];
      default: allowed = 1'b0;
    endcase
  end

  wire [IDX_W-1:0] ptr_nx = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (flush_all) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (ld_en) begin
      tag_q[ptr_q]   <= ld_vpn;
      ppn_q[ptr_q]   <= ld_ppn;
      perm_q[ptr_q]  <= {ld_ex, ld_wr, ld_rd};
      valid_q[ptr_q] <= ld_valid;
      ptr_q          <= ptr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit && allowed;
      rsp_miss  <= req_valid && !any_hit;
      rsp_fault <= req_valid && any_hit && !allowed;
      rsp_multi <= req_valid && multi;
      rsp_paddr <= (req_valid && any_hit && allowed) ? {ppn_q[win], req_off} : '0;
    end
  end

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  assert_quiet_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_multi));
  assert_paddr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> rsp_paddr == '0);
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 rsp_hit) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0 && ptr_q == '0));
  assert_multi_needs_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_hit || rsp_fault));
  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flush_all) |=> ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !flush_all) |=> $stable(ptr_q));

endmodule

// File: tb/sim_page_xlate_buf.sv
module sim_page_xlate_buf;
  localparam int N = 8, VA_W = 24, OFF_W = 10, PPN_W = 12;
  localparam int VPN_W = VA_W - OFF_W, PA_W = PPN_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ld_en = 0, ld_valid = 0, ld_rd = 0, ld_wr = 0, ld_ex = 0, flush_all = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic [VPN_W-1:0] ld_vpn = '0;
  logic [PPN_W-1:0] ld_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi;
  logic [PA_W-1:0] rsp_paddr;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_xlate_buf #(.ENTRIES(N), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u0 (
    .clk, .rst_n, .req_valid, .req_vaddr, .req_kind, .ld_en, .ld_vpn, .ld_ppn,
    .ld_valid, .ld_rd, .ld_wr, .ld_ex, .flush_all, .rsp_valid, .rsp_hit,
    .rsp_miss, .rsp_fault, .rsp_multi, .rsp_paddr);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outcome: 0 hit, 1 miss, 2 fault
  task automatic expect_rsp(input string req, input int outcome, input bit multi, input logic [PA_W-1:0] pa);
    logic [3:0] got, want;
    got  = {rsp_valid, rsp_hit, rsp_miss, rsp_fault};
    want = {1'b1, outcome == 0, outcome == 1, outcome == 2};
    chk(got == want, {req, " outcome/R11"}, got, want);
    chk(rsp_multi == multi, {req, " multi"}, rsp_multi, multi);
    chk(rsp_paddr == pa, {req, " paddr"}, rsp_paddr, pa);
  endtask

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off, input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_kind = kind;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic load(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input bit v, input bit r, input bit w, input bit x);
    @(negedge clk);
    ld_en = 1; ld_vpn = vpn; ld_ppn = ppn; ld_valid = v; ld_rd = r; ld_wr = w; ld_ex = x;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    lookup('0, '0, 2'b00);
    expect_rsp("R1 empty lookup", 1, 0, '0);
    lookup(14'h0123, 10'h3ff, 2'b10);
    expect_rsp("R4 no match", 1, 0, '0);
  endtask

  task automatic t_hit();
    load(14'h0123, 12'habc, 1, 1, 1, 1);
    lookup(14'h0123, 10'h3ff, 2'b00);
    expect_rsp("R3 read hit", 0, 0, {12'habc, 10'h3ff});
    lookup(14'h0123, 10'h001, 2'b01);
    expect_rsp("R3 write hit", 0, 0, {12'habc, 10'h001});
    lookup(14'h0123, 10'h155, 2'b10);
    expect_rsp("R3 fetch hit", 0, 0, {12'habc, 10'h155});
    @(negedge clk);
    chk(rsp_valid == 0, "R2 idle gives no response", rsp_valid, 0);
  endtask

  task automatic t_invalid();
    load(14'h0055, 12'h777, 0, 1, 1, 1);
    lookup(14'h0055, 10'h010, 2'b00);
    expect_rsp("R5 invalid entry", 1, 0, '0);
  endtask

  task automatic t_perm();
    load(14'h0200, 12'h321, 1, 1, 0, 0);
    load(14'h0201, 12'h654, 1, 0, 1, 1);
    lookup(14'h0200, 10'h00f, 2'b00);
    expect_rsp("R6 read allowed", 0, 0, {12'h321, 10'h00f});
    lookup(14'h0200, 10'h00f, 2'b01);
    expect_rsp("R6 write denied", 2, 0, '0);
    lookup(14'h0200, 10'h00f, 2'b10);
    expect_rsp("R6 fetch denied", 2, 0, '0);
    lookup(14'h0201, 10'h0aa, 2'b00);
    expect_rsp("R6 read denied", 2, 0, '0);
    lookup(14'h0201, 10'h0aa, 2'b01);
    expect_rsp("R6 write allowed", 0, 0, {12'h654, 10'h0aa});
    lookup(14'h0201, 10'h0aa, 2'b10);
    expect_rsp("R6 fetch allowed", 0, 0, {12'h654, 10'h0aa});
    lookup(14'h0201, 10'h0aa, 2'b11);
    expect_rsp("R6 reserved kind", 2, 0, '0);
  endtask

  task automatic t_multi();
    flush();
    load(14'h0077, 12'h111, 1, 1, 1, 1);
    lookup(14'h0077, 10'h020, 2'b00);
    expect_rsp("R9 single match", 0, 0, {12'h111, 10'h020});
    load(14'h0077, 12'h222, 1, 1, 1, 1);
    lookup(14'h0077, 10'h020, 2'b00);
    expect_rsp("R9 lowest slot wins", 0, 1, {12'h111, 10'h020});
  endtask

  task automatic t_round_robin();
    flush();
    for (int i = 0; i < N; i++) load(14'h0300 + 14'(i), 12'(i + 1), 1, 1, 1, 1);
    lookup(14'h0300, 10'h000, 2'b00);
    expect_rsp("R7 slot 0 before wrap", 0, 0, {12'h001, 10'h000});
    load(14'h0400, 12'h0ee, 1, 1, 1, 1);
    lookup(14'h0300, 10'h000, 2'b00);
    expect_rsp("R7 oldest replaced", 1, 0, '0);
    lookup(14'h0301, 10'h004, 2'b00);
    expect_rsp("R7 slot 1 kept", 0, 0, {12'h002, 10'h004});
    lookup(14'h0400, 10'h004, 2'b00);
    expect_rsp("R7 wrapped load", 0, 0, {12'h0ee, 10'h004});
  endtask

  task automatic t_flush();
    flush();
    lookup(14'h0301, 10'h004, 2'b00);
    expect_rsp("R8 flush clears", 1, 0, '0);
    load(14'h0500, 12'h050, 1, 1, 1, 1);
    @(negedge clk);
    flush_all = 1; ld_en = 1; ld_vpn = 14'h0600; ld_ppn = 12'h060;
    ld_valid = 1; ld_rd = 1; ld_wr = 1; ld_ex = 1;
    @(negedge clk);
    flush_all = 0; ld_en = 0;
    lookup(14'h0600, 10'h000, 2'b00);
    expect_rsp("R8 load dropped under flush", 1, 0, '0);
    lookup(14'h0500, 10'h000, 2'b00);
    expect_rsp("R8 prior entry flushed", 1, 0, '0);
    // pointer back at 0: first load survives N-1 more loads
    load(14'h0700, 12'h070, 1, 1, 1, 1);
    for (int i = 1; i < N; i++) load(14'h0800 + 14'(i), 12'h080, 1, 1, 1, 1);
    lookup(14'h0700, 10'h001, 2'b00);
    expect_rsp("R8 pointer reset to slot 0", 0, 0, {12'h070, 10'h001});
  endtask

  task automatic t_same_cycle();
    flush();
    @(negedge clk);
    req_valid = 1; req_vaddr = {14'h0999, 10'h033}; req_kind = 2'b00;
    ld_en = 1; ld_vpn = 14'h0999; ld_ppn = 12'h999;
    ld_valid = 1; ld_rd = 1; ld_wr = 1; ld_ex = 1;
    @(negedge clk);
    req_valid = 0; ld_en = 0;
    expect_rsp("R10 lookup sees old contents", 1, 0, '0);
    lookup(14'h0999, 10'h033, 2'b00);
    expect_rsp("R10 next lookup hits", 0, 0, {12'h999, 10'h033});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hit();
    t_invalid();
    t_perm();
    t_multi();
    t_round_robin();
    t_flush();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule